// File: doc/BRIEF.md
# Multi-Channel Timer Compare Unit

The block holds a free-running up-counter and a set of compare registers, four by default. Every cycle each register is tested against the count. The result is a level compare signal that stays active for as long as the count equals the register. Each enabled channel turns that signal into an output pin and a single-cycle interrupt request.

In PWM compare mode the pin rises on a match and falls when the counter wraps. Software sets a duty cycle once by writing a compare value, and the pin then oscillates on its own. In direct mode, and for any channel that is not enabled, the pin follows a software port latch. That latch cannot be written while its channel is enabled in PWM mode.

Configuration uses a plain register write strobe. It is a control path and has no valid/ready handshake. A write is accepted in any cycle in which `cfg_we` is high, and it takes effect from the next cycle. The latch write strobe behaves the same way.

Top module: `cmp_timer_unit`

## Requirements
- R1: The count is 0 in reset. It rises by one every cycle and wraps from its maximum value (2^CNT_W-1) to 0. The cycle in which the count is 0 is the overflow cycle, and the first cycle after reset counts as one.
- R2: For an enabled channel in PWM mode with compare value C other than 0, the pin goes high in the same cycle in which the count equals C. It stays high up to and including the maximum count.
- R3: For an enabled channel in PWM mode, the pin is low in the overflow cycle. When C is 0, the overflow wins over the coincident match, so the pin stays low for the whole period.
- R4: On channels 1 to 3, the interrupt is a one-cycle pulse in the cycle in which the count first equals the compare value. This is the rising edge of the compare signal.
- R5: Control bit 5 selects the interrupt edge for channel 0. At 0 the pulse comes in the cycle where the count equals C. At 1 it comes in the cycle after, where the count equals (C+1) mod 2^CNT_W, when the compare signal goes inactive.
- R6: A latch write is ignored for each channel that is enabled in PWM mode. The write is taken for all other channels.
- R7: A channel whose enable bit is 0 drives its pin from its latch bit and never raises an interrupt.
- R8: When control bit 4 is 1 (direct mode), enabled channels drive their pins from their latch bits. Their latch bits stay writable, and their interrupts still fire.
- R9: Addresses 0 to 3 write the compare value of that channel from the low CNT_W bits of the data. Address 4 writes the control word: bits 3:0 are the channel enables, bit 4 is the mode and bit 5 is the channel-0 edge select. Data bits above those fields are ignored.
- R10: In reset, all pins and interrupts are low, and all compare values, control bits and latch bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0-3 compare, 4 control) |
| cfg_wdata | input | 16 | Register write data |
| latch_we | input | 1 | Port latch write strobe |
| latch_wdata | input | 4 | Port latch data, one bit per channel |
| tmr_count | output | 16 | Current counter value |
| cmp_pin | output | 4 | Channel output pins |
| cmp_irq | output | 4 | Channel interrupt request pulses |

## Verification
The bench runs the counter at 6 bits and sweeps every compare value on every channel. It does this once with rising-edge and once with falling-edge selection on channel 0. It checks pins and interrupts against arithmetic formulas in every cycle of a full period. That sweep exposes four kinds of error. A design that lets the match win over the wrap would hold the pin high for a whole period at C=0. One that registers the pin would rise a cycle late. One that takes the wrong edge would pulse at C instead of C+1, and C=63 checks the falling edge across the wrap. Latch tests write all channels while only some are locked, then bring the latch bits out to the pins, so a design that lets a locked write through shows the wrong pattern.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef enum logic {
    MODE_PWM    = 1'b0,
    MODE_DIRECT = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/cmpu_timer.sv
module cmpu_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  // ovf_q marks the cycle in which the count sits at zero after a wrap.
  // It resets high so the first cycle is also a period start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      ovf_q <= (cnt_q == CNT_MAX);
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1) && !ovf); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == '0) && ovf); // R1
endmodule

// File: rtl/cmpu_cfg_regs.sv
module cmpu_cfg_regs
  import cmpu_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [CFG_W-1:0]            cfg_wdata,
  input  logic                        latch_we,
  input  logic [N_CH-1:0]             latch_wdata,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_val,
  output logic [N_CH-1:0]             ch_en,
  output cmp_mode_e                   mode,
  output logic                        ch0_fall,
  output logic [N_CH-1:0]             latch_q
);
  localparam int MODE_BIT = N_CH;
  localparam int EDGE_BIT = N_CH + 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CH);

  logic [N_CH-1:0] lock;
  logic            ctrl_hit;
  logic            unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign ctrl_hit     = cfg_we && (cfg_addr == CTRL_ADDR);

  for (genvar i = 0; i < N_CH; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_val[i] <= '0;
      end else if (cfg_we && (cfg_addr == ADDR_W'(i))) begin
        cmp_val[i] <= cfg_wdata[CNT_W-1:0];
      end
    end

    // A channel running in PWM compare mode owns its pin; the latch is locked.
    assign lock[i] = ch_en[i] && (mode == MODE_PWM);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch_q[i] <= 1'b0;
      end else if (latch_we && !lock[i]) begin
        latch_q[i] <= latch_wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en    <= '0;
      mode     <= MODE_PWM;
      ch0_fall <= 1'b0;
    end else if (ctrl_hit) begin
      ch_en    <= cfg_wdata[N_CH-1:0];
      mode     <= cmp_mode_e'(cfg_wdata[MODE_BIT]);
      ch0_fall <= cfg_wdata[EDGE_BIT];
    end
  end

  AST_LATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|lock) |=> (((latch_q ^ $past(latch_q)) & $past(lock)) == '0)); // R6
endmodule

// File: rtl/cmpu_channel.sv
module cmpu_channel
  import cmpu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             en,
  input  cmp_mode_e        mode,
  input  logic             fall_sel,
  input  logic             latch_bit,
  output logic             pin,
  output logic             irq
);
  logic match;
  logic hit;
  logic hit_q;
  logic pwm_q;
  logic pwm_nxt;
  logic rise_ev;
  logic fall_ev;

  // Level compare signal: active for every cycle the count equals the value.
  assign match = (cnt == cmp_val);
  assign hit   = en && match;

  // Wrap has priority over match so that C=0 yields a pin that never rises.
  always_comb begin
    if (ovf)        pwm_nxt = 1'b0;
    else if (match) pwm_nxt = 1'b1;
    else            pwm_nxt = pwm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      pwm_q <= pwm_nxt;
      hit_q <= hit;
    end
  end

  // The pin takes its new value in the match cycle itself.
  assign pin = (en && (mode == MODE_PWM)) ? pwm_nxt : latch_bit;

  assign rise_ev = hit && !hit_q;
  assign fall_ev = !hit && hit_q;
  assign irq     = en && (fall_sel ? fall_ev : rise_ev);

  AST_PIN_UP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode == MODE_PWM) && (cnt == cmp_val) && !ovf) |-> pin); // R2
  AST_PIN_LOW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode == MODE_PWM) && ovf) |-> !pin); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq || (fall_sel != $past(fall_sel)))); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq); // R7
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import cmpu_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16,
  parameter int ADDR_W = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              latch_we,
  input  logic [N_CH-1:0]   latch_wdata,
  output logic [CNT_W-1:0]  tmr_count,
  output logic [N_CH-1:0]   cmp_pin,
  output logic [N_CH-1:0]   cmp_irq
);
  logic [CNT_W-1:0]            cnt;
  logic                        ovf;
  logic [N_CH-1:0][CNT_W-1:0]  cmp_val;
  logic [N_CH-1:0]             ch_en;
  cmp_mode_e                   mode;
  logic                        ch0_fall;
  logic [N_CH-1:0]             latch_q;

  cmpu_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .ovf   (ovf)
  );

  cmpu_cfg_regs #(
    .N_CH   (N_CH),
    .CNT_W  (CNT_W),
    .CFG_W  (CFG_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .latch_we    (latch_we),
    .latch_wdata (latch_wdata),
    .cmp_val     (cmp_val),
    .ch_en       (ch_en),
    .mode        (mode),
    .ch0_fall    (ch0_fall),
    .latch_q     (latch_q)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    // Only channel 0 may pick the falling edge; the rest are tied to rising.
    logic fall_sel;
    if (i == 0) begin : g_sel0
      assign fall_sel = ch0_fall;
    end else begin : g_seln
      assign fall_sel = 1'b0;
    end

    cmpu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .ovf       (ovf),
      .cmp_val   (cmp_val[i]),
      .en        (ch_en[i]),
      .mode      (mode),
      .fall_sel  (fall_sel),
      .latch_bit (latch_q[i]),
      .pin       (cmp_pin[i]),
      .irq       (cmp_irq[i])
    );
  end

  assign tmr_count = cnt;
endmodule

// File: tb/cmp_timer_unit_tb.sv
module cmp_timer_unit_tb;
  localparam int N_CH  = 4;
  localparam int CNT_W = 6;
  localparam int PER   = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [15:0]      cfg_wdata = '0;
  logic             latch_we = 1'b0;
  logic [3:0]       latch_wdata = '0;
  logic [CNT_W-1:0] tmr_count;
  logic [3:0]       cmp_pin;
  logic [3:0]       cmp_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer_unit #(.N_CH(N_CH), .CNT_W(CNT_W), .CFG_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .latch_we(latch_we), .latch_wdata(latch_wdata),
    .tmr_count(tmr_count), .cmp_pin(cmp_pin), .cmp_irq(cmp_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_latch(input int data);
    @(negedge clk);
    latch_we = 1'b1; latch_wdata = 4'(data);
    @(negedge clk);
    latch_we = 1'b0;
  endtask

  task automatic wait_count(input int t);
    while (int'(tmr_count) != t) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c[4];
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 count", int'(tmr_count), 0);
    check("R10 pins", int'(cmp_pin), 0);
    check("R10 irq", int'(cmp_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first step", int'(tmr_count), 1);

    // R2 R3 R4 R5 R1 R9: full sweep over all compare values, both ch0 edges
    for (int fs = 0; fs < 2; fs++) begin
      for (int k = 0; k < PER; k++) begin
        for (int i = 0; i < N_CH; i++) begin
          c[i] = (k + 17 * i) % PER;
          wr(i, c[i] | 16'hFFC0);  // R9: upper data bits ignored
        end
        wr(4, 32'h0F | (fs << 5));
        wait_count(PER - 1);
        @(negedge clk);
        @(negedge clk);
        for (int s = 0; s < PER; s++) begin
          int t;
          t = (1 + s) % PER;
          check("R1 count", int'(tmr_count), t);
          for (int i = 0; i < N_CH; i++) begin
            int pe, ie;
            pe = (c[i] != 0 && t >= c[i]) ? 1 : 0;
            if (c[i] == 0) check("R3 pin C=0", int'(cmp_pin[i]), pe);
            else if (t == 0) check("R3 pin at wrap", int'(cmp_pin[i]), pe);
            else check("R2 pin", int'(cmp_pin[i]), pe);
            if (i == 0) begin
              ie = (fs == 1) ? ((t == (c[0] + 1) % PER) ? 1 : 0)
                             : ((t == c[0]) ? 1 : 0);
              check("R5 ch0 irq", int'(cmp_irq[0]), ie);
            end else begin
              ie = (t == c[i]) ? 1 : 0;
              check("R4 irq", int'(cmp_irq[i]), ie);
            end
          end
          @(negedge clk);
        end
      end
    end

    // R6: channels 0 and 2 enabled in PWM mode, latch write to all
    wr(4, 32'h05);
    wr_latch(4'hF);
    wr(4, 32'h00);
    @(negedge clk);
    check("R6 locked latch bits", int'(cmp_pin), 4'b1010);

    // R7: all disabled, no interrupts over a whole period
    for (int s = 0; s < PER; s++) begin
      check("R7 no irq disabled", int'(cmp_irq), 0);
      check("R7 pin follows latch", int'(cmp_pin), 4'b1010);
      @(negedge clk);
    end

    // R8: direct mode, all enabled, latch writable, irq still fires
    wr(1, 5);
    wr(4, 32'h1F);
    wr_latch(4'h6);
    check("R8 direct pins", int'(cmp_pin), 4'b0110);
    wait_count(5);
    check("R8 irq in direct mode", int'(cmp_irq[1]), 1);
    check("R8 pin still latch", int'(cmp_pin), 4'b0110);
    wr_latch(4'h9);
    check("R8 latch rewrite", int'(cmp_pin), 4'b1001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule